// File: doc/BRIEF.md
# Floating-Point Significand Rounding Stage

This block sits at the end of a floating-point datapath, after the significand has been normalized. It takes a kept significand, the three bits that lie below it (guard, round, sticky), the sign of the value and a two-bit rounding mode. It decides whether the kept significand must grow by one unit in its last place, and performs that increment. It reports a carry-out when the increment wraps an all-ones significand, which tells the exponent stage to add one. It also flags any result that is not exact.

Operands arrive and results leave on valid/ready streams with one register stage between them. An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output side in the following cycle. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While the result is held back, it stays unchanged and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`, so a full throughput of one operand per cycle is possible when the consumer is always ready. Nothing upstream or downstream needs to hold anything longer than one handshake.

Top module: `fp_round_unit`

## Requirements
- R1: In mode 2'b00 (nearest, ties to even), a clear guard bit leaves the significand unchanged.
- R2: In mode 2'b00, a set guard bit together with a set round or sticky bit adds one to the significand.
- R3: In mode 2'b00, an exact half (guard set, round and sticky clear) adds one only when bit 0 of the significand is 1, and otherwise leaves it unchanged.
- R4: In mode 2'b01 (toward zero), the significand is never incremented.
- R5: In mode 2'b10 (toward positive infinity), the significand is incremented exactly when some dropped bit is set and the sign bit is 0.
- R6: In mode 2'b11 (toward negative infinity), the significand is incremented exactly when some dropped bit is set and the sign bit is 1.
- R7: `out_inexact` is the OR of guard, round and sticky; when all three are 0, the significand passes through unchanged in every mode.
- R8: When an increment is applied to an all-ones significand, `out_carry` is 1 and `out_sig` is a 1 in the top bit followed by zeros; in every other case `out_carry` is 0.
- R9: `out_sign` equals the sign of the accepted operand.
- R10: A result appears one cycle after its operand is accepted, and stays unchanged while `out_valid` is high and `out_ready` is low; `in_ready` is then low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can accept an operand |
| in_sig | input | SIG_W | Kept significand before rounding |
| in_guard | input | 1 | First dropped bit |
| in_round | input | 1 | Second dropped bit |
| in_sticky | input | 1 | OR of all remaining dropped bits |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | SIG_W | Rounded significand |
| out_carry | output | 1 | Increment wrapped; exponent must grow by one |
| out_inexact | output | 1 | Some dropped bit was set |
| out_sign | output | 1 | Sign carried with the result |

## Verification
The hardest case to reach is the carry-out, which needs an all-ones significand together with a mode, sign and dropped-bit pattern that calls for an increment; the tie rule in nearest mode likewise depends on the exact pattern 1-0-0 below a significand whose last bit is set. With a four-bit significand the bench sweeps every significand, every dropped-bit pattern, both signs and all four modes, so each of these corners is visited many times. A separate sequence holds `out_ready` low while a second operand waits, to show that the held result does not change and that the waiting operand is taken once the consumer frees the register.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

  // Rounding mode codes seen on in_mode.
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;

endpackage

// File: rtl/rnd_decide.sv
// Decides whether the kept significand must grow by one unit in the last place.
module rnd_decide
  import fp_round_pkg::*;
(
  input  logic       lsb_i,
  input  logic       guard_i,
  input  logic       round_i,
  input  logic       sticky_i,
  input  logic       sign_i,
  input  logic [1:0] mode_i,
  output logic       inc_o,
  output logic       inexact_o
);

  logic below_half_nz;  // any dropped bit beneath the guard position
  logic any_dropped;
  rmode_e mode;

  always_comb begin
    mode         = rmode_e'(mode_i);
    below_half_nz = round_i | sticky_i;
    any_dropped  = guard_i | below_half_nz;
    inexact_o    = any_dropped;
    unique case (mode)
      RM_NEAR_EVEN: inc_o = guard_i & (below_half_nz | lsb_i);
      RM_TO_ZERO:   inc_o = 1'b0;
      RM_TO_POS:    inc_o = any_dropped & ~sign_i;
      RM_TO_NEG:    inc_o = any_dropped & sign_i;
      default:      inc_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!(guard_i | round_i | sticky_i)) begin
      assert_exact_noinc_R7: assert (!inc_o);
    end
    if (mode_i == 2'b01) begin
      assert_tz_noinc_R4: assert (!inc_o);
    end
    if (mode_i == 2'b00 && !guard_i) begin
      assert_near_below_half_R1: assert (!inc_o);
    end
  end

endmodule

// File: rtl/rnd_incr.sv
// Adds the rounding increment and renormalizes on wrap-around.
module rnd_incr #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             inc_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o
);

  localparam int SUM_W = SIG_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_i};
    carry_o = sum[SUM_W-1];
    // On wrap the low bits are all zero; shifting right brings the carry in on top.
    sig_o   = carry_o ? sum[SUM_W-1:1] : sum[SIG_W-1:0];
  end

  always_comb begin
    assert_carry_only_on_wrap_R8: assert (carry_o == (inc_i && (&sig_i)));
  end

endmodule

// File: rtl/rnd_out_reg.sv
// One-entry output register with a valid/ready handshake on both sides.
module rnd_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (in_ready) begin
      full_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      data_q <= in_data;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_accept_gives_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |-> (out_valid && !out_ready));

endmodule

// File: rtl/fp_round_unit.sv
// Rounding stage: decide, increment, register.
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_guard,
  input  logic             in_round,
  input  logic             in_sticky,
  input  logic             in_sign,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_carry,
  output logic             out_inexact,
  output logic             out_sign
);

  // Payload layout: {sign, inexact, carry, significand}
  localparam int PAY_W = SIG_W + 3;

  logic             inc;
  logic             inexact;
  logic [SIG_W-1:0] rounded;
  logic             carry;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  rnd_decide u_decide (
    .lsb_i     (in_sig[0]),
    .guard_i   (in_guard),
    .round_i   (in_round),
    .sticky_i  (in_sticky),
    .sign_i    (in_sign),
    .mode_i    (in_mode),
    .inc_o     (inc),
    .inexact_o (inexact)
  );

  rnd_incr #(.SIG_W(SIG_W)) u_incr (
    .sig_i   (in_sig),
    .inc_i   (inc),
    .sig_o   (rounded),
    .carry_o (carry)
  );

  assign pay_in = {in_sign, inexact, carry, rounded};

  rnd_out_reg #(.DATA_W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_sig     = pay_out[SIG_W-1:0];
  assign out_carry   = pay_out[SIG_W];
  assign out_inexact = pay_out[SIG_W+1];
  assign out_sign    = pay_out[SIG_W+2];

  assert_carry_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_carry) |-> (out_sig == {1'b1, {(SIG_W-1){1'b0}}}));

  assert_carry_needs_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_carry) |-> out_inexact);

  assert_sign_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_sign == $past(in_sign)));

endmodule

// File: tb/fp_round_unit_bench.sv
module fp_round_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_sig = '0;
  logic         in_guard = 1'b0;
  logic         in_round = 1'b0;
  logic         in_sticky = 1'b0;
  logic         in_sign = 1'b0;
  logic [1:0]   in_mode = 2'b00;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sig;
  logic         out_carry;
  logic         out_inexact;
  logic         out_sign;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_unit #(.SIG_W(W)) u_fp_round_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sig(in_sig), .in_guard(in_guard), .in_round(in_round),
    .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sig(out_sig), .out_carry(out_carry),
    .out_inexact(out_inexact), .out_sign(out_sign)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result from the requirements.
  task automatic expect_of(input int sig, input int grs, input int sign, input int mode,
                           output int e_sig, output int e_carry, output int e_inx,
                           output string tag);
    int g, r, s, any, inc, sum;
    g = (grs >> 2) & 1; r = (grs >> 1) & 1; s = grs & 1;
    any = (g | r | s);
    case (mode)
      0: begin
        if (g == 0) begin inc = 0; tag = "R1"; end
        else if ((r | s) != 0) begin inc = 1; tag = "R2"; end
        else begin inc = sig & 1; tag = "R3"; end
      end
      1: begin inc = 0; tag = "R4"; end
      2: begin inc = any & (1 - sign); tag = "R5"; end
      default: begin inc = any & sign; tag = "R6"; end
    endcase
    if (any == 0) tag = "R7";
    sum = sig + inc;
    if (sum == (1 << W)) begin e_carry = 1; e_sig = 1 << (W - 1); end
    else begin e_carry = 0; e_sig = sum; end
    e_inx = any;
  endtask

  task automatic drive(input int sig, input int grs, input int sign, input int mode);
    in_sig    = W'(sig);
    in_guard  = grs[2];
    in_round  = grs[1];
    in_sticky = grs[0];
    in_sign   = sign[0];
    in_mode   = mode[1:0];
    in_valid  = 1'b1;
  endtask

  task automatic run_vec(input int sig, input int grs, input int sign, input int mode);
    int e_sig, e_carry, e_inx;
    string tag;
    @(negedge clk);
    drive(sig, grs, sign, mode);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    expect_of(sig, grs, sign, mode, e_sig, e_carry, e_inx, tag);
    check("R10 out_valid", int'(out_valid), 1);
    check(tag, int'(out_sig), e_sig);
    check("R8 carry", int'(out_carry), e_carry);
    check("R7 inexact", int'(out_inexact), e_inx);
    check("R9 sign", int'(out_sign), sign);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", int'(out_valid), 0);
    check("R11 in_ready after reset", int'(in_ready), 1);

    // Full sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int sign = 0; sign < 2; sign++)
      for (int mode = 0; mode < 4; mode++)
        for (int sig = 0; sig < (1 << W); sig++)
          for (int grs = 0; grs < 8; grs++)
            run_vec(sig, grs, sign, mode);

    // R10: back-pressure. A = all ones, exact tie, nearest -> carry, 1000.
    @(negedge clk);
    out_ready = 1'b0;
    drive(15, 3'b100, 0, 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R10 A valid", int'(out_valid), 1);
    check("R8 A sig", int'(out_sig), 8);
    check("R8 A carry", int'(out_carry), 1);
    // B = 0010 with guard and round, nearest -> 0011, waits
    drive(2, 3'b110, 1, 0);
    check("R10 in_ready low while stalled", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 A held sig", int'(out_sig), 8);
    check("R10 A held carry", int'(out_carry), 1);
    check("R10 A held sign", int'(out_sign), 0);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R10 B valid", int'(out_valid), 1);
    check("R2 B sig", int'(out_sig), 3);
    check("R8 B carry", int'(out_carry), 0);
    check("R9 B sign", int'(out_sign), 1);
    @(negedge clk);
    check("R10 drained", int'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule